// File: doc/BRIEF.md
# Flag Offset Register Port

This block keeps the two threshold offsets that a synchronous FIFO's partial flags compare against: `n`, the almost-empty distance, and `m`, the almost-full distance. Each offset is held as a low register as wide as the data bus and a high register that holds the remaining offset bits. Software reaches all four registers through the FIFO's own data buses. There is no address bus. A shared active-low load strobe takes the place of one, and each side has a selector that rotates through the registers in a fixed order.

Writes run on the write clock and are qualified by the write enable. Readback runs on the read clock and is qualified by the read enable. Each clock domain has its own selector. Both selectors keep their position between separate load sessions, so a partial update can be resumed later. The load pin acts as a load strobe only if it was held low while reset was applied. Otherwise it is ignored, and every enabled access is a plain FIFO access. The assembled `n` and `m` values are driven to the flag comparison logic, which sits outside this block.

Top module: `offset_port`

## Requirements
- R1: The four registers are visited in the order empty-low (selector 0), empty-high (1), full-low (2), full-high (3). After full-high, the next access goes to empty-low again. This order applies to writes and to readback.
- R2: In programming mode, a rising write-clock edge with `loadN` low and `wrEnN` low stores `wrData` into the selected register and advances the write selector by one.
- R3: While `wrEnN` is high, no register and no selector changes, whatever the level of `loadN`. With `loadN` high and `wrEnN` low, `fifoWr` is high, and the offsets and the write selector stay unchanged.
- R4: If `loadN` is raised partway through the sequence, the next load session writes to the register that follows the last one written. It does not restart at empty-low.
- R5: A rising read-clock edge with `loadN` low and `rdEnN` low (programming mode) registers the selected register onto `offRdData` and advances the read selector. At all other edges, `offRdData` holds its value. The read selector also keeps its position between sessions.
- R6: After reset, both low registers hold 7 and both high registers hold 0, so `emptyOff` and `fullOff` both read 7.
- R7: Programming mode is captured from `loadN` at the clock edges where `rstN` is low. If `loadN` was high there, load-low accesses do not touch the offsets, and `fifoWr` / `fifoRd` follow the enables alone.
- R8: `emptyOff` equals {empty-high, empty-low}, and `fullOff` equals {full-high, full-low}, with the low register in bits [DATA_W-1:0].
- R9: Each high register holds OFF_W-DATA_W bits (7 by default). Input bits above those are discarded on write, and the unused bits read back as zero.
- R10: Reset returns both selectors to empty-low.
- R11: In programming mode, `rdEnN` low with `loadN` high raises `fifoRd` and leaves `offRdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Synchronous active-low reset, sampled by both clocks |
| loadN | input | 1 | Active-low load strobe; its level during reset selects programming mode |
| wrEnN | input | 1 | Active-low write enable |
| rdEnN | input | 1 | Active-low read enable |
| wrData | input | DATA_W | Write data bus |
| offRdData | output | DATA_W | Registered readback of the selected offset register |
| fifoWr | output | 1 | The current write-side access is a FIFO write |
| fifoRd | output | 1 | The current read-side access is a FIFO read |
| emptyOff | output | OFF_W | Assembled almost-empty offset n |
| fullOff | output | OFF_W | Assembled almost-full offset m |

## Verification
The hardest state to reach is a selector parked mid-sequence across an idle gap, because no port reveals the selector's position. The stimulus writes one register, drops the load strobe for several cycles, and writes again. It then infers the selector position from which half of `emptyOff` or `fullOff` moved. Readback is exercised the same way, with a pause between two reads, and the wrap is forced with a fifth consecutive write. Non-programming mode needs a separate reset with `loadN` held high.

// File: rtl/offset_port_pkg.sv
package offset_port_pkg;

  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } offSel_e;

  typedef struct packed {
    logic    wrLoad;
    offSel_e wrSel;
    logic    rdLoad;
    offSel_e rdSel;
  } offStrb_t;

endpackage

// File: rtl/offset_port_ctrl.sv
module offset_port_ctrl
  import offset_port_pkg::*;
(
  input  logic     wrClk,
  input  logic     rdClk,
  input  logic     rstN,
  input  logic     loadN,
  input  logic     wrEnN,
  input  logic     rdEnN,
  output offStrb_t strb,
  output logic     fifoWr,
  output logic     fifoRd
);

  logic    progW, progR;
  offSel_e wrSelQ, rdSelQ;
  logic    wrLoad, rdLoad;

  assign wrLoad = rstN & progW & ~loadN & ~wrEnN;
  assign rdLoad = rstN & progR & ~loadN & ~rdEnN;
  assign fifoWr = rstN & ~wrEnN & (loadN | ~progW);
  assign fifoRd = rstN & ~rdEnN & (loadN | ~progR);

  // write-side selector and mode capture
  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      progW  <= ~loadN;
      wrSelQ <= SEL_EMPTY_LO;
    end else if (wrLoad) begin
      wrSelQ <= offSel_e'(wrSelQ + 2'd1);
    end
  end

  // read-side selector and mode capture
  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      progR  <= ~loadN;
      rdSelQ <= SEL_EMPTY_LO;
    end else if (rdLoad) begin
      rdSelQ <= offSel_e'(rdSelQ + 2'd1);
    end
  end

  always_comb begin
    strb.wrLoad = wrLoad;
    strb.wrSel  = wrSelQ;
    strb.rdLoad = rdLoad;
    strb.rdSel  = rdSelQ;
  end

  AST_WR_EXCL: assert property (@(posedge wrClk) disable iff (!rstN)
    !(fifoWr && wrLoad)); // R3
  AST_RD_EXCL: assert property (@(posedge rdClk) disable iff (!rstN)
    !(fifoRd && rdLoad)); // R11
  AST_WSEL_PARK: assert property (@(posedge wrClk) disable iff (!rstN)
    wrEnN |=> $stable(wrSelQ)); // R4
  AST_RSEL_PARK: assert property (@(posedge rdClk) disable iff (!rstN)
    rdEnN |=> $stable(rdSelQ)); // R5

endmodule

// File: rtl/offset_port_dp.sv
module offset_port_dp
  import offset_port_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFF_W  = 16
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  offStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] offRdData,
  output logic [OFF_W-1:0]  emptyOff,
  output logic [OFF_W-1:0]  fullOff
);

  localparam int HI_W  = OFF_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;
  localparam logic [DATA_W-1:0] LO_RST = DATA_W'(7);

  logic [DATA_W-1:0] eLoQ, fLoQ;
  logic [HI_W-1:0]   eHiQ, fHiQ;
  logic [DATA_W-1:0] eHiExt, fHiExt, rdMux;

  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      eLoQ <= LO_RST;
      fLoQ <= LO_RST;
      eHiQ <= '0;
      fHiQ <= '0;
    end else if (strb.wrLoad) begin
      case (strb.wrSel)
        SEL_EMPTY_LO: eLoQ <= wrData;
        SEL_EMPTY_HI: eHiQ <= wrData[HI_W-1:0];
        SEL_FULL_LO:  fLoQ <= wrData;
        default:      fHiQ <= wrData[HI_W-1:0];
      endcase
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign eHiExt = {{PAD_W{1'b0}}, eHiQ};
      assign fHiExt = {{PAD_W{1'b0}}, fHiQ};
    end else begin : g_nopad
      assign eHiExt = eHiQ;
      assign fHiExt = fHiQ;
    end
  endgenerate

  always_comb begin
    case (strb.rdSel)
      SEL_EMPTY_LO: rdMux = eLoQ;
      SEL_EMPTY_HI: rdMux = eHiExt;
      SEL_FULL_LO:  rdMux = fLoQ;
      default:      rdMux = fHiExt;
    endcase
  end

  always_ff @(posedge rdClk) begin
    if (!rstN)              offRdData <= '0;
    else if (strb.rdLoad)   offRdData <= rdMux;
  end

  assign emptyOff = {eHiQ, eLoQ};
  assign fullOff  = {fHiQ, fLoQ};

  AST_LOAD_ELO: assert property (@(posedge wrClk) disable iff (!rstN)
    (strb.wrLoad && strb.wrSel == SEL_EMPTY_LO) |=> emptyOff[DATA_W-1:0] == $past(wrData)); // R2
  AST_LOAD_FLO: assert property (@(posedge wrClk) disable iff (!rstN)
    (strb.wrLoad && strb.wrSel == SEL_FULL_LO) |=> fullOff[DATA_W-1:0] == $past(wrData)); // R8
  AST_IDLE_HOLD: assert property (@(posedge wrClk) disable iff (!rstN)
    !strb.wrLoad |=> ($stable(emptyOff) && $stable(fullOff))); // R3
  AST_RD_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    !strb.rdLoad |=> $stable(offRdData)); // R5

endmodule

// File: rtl/offset_port.sv
module offset_port
  import offset_port_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFF_W  = 16
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] offRdData,
  output logic              fifoWr,
  output logic              fifoRd,
  output logic [OFF_W-1:0]  emptyOff,
  output logic [OFF_W-1:0]  fullOff
);

  offStrb_t strb;

  offset_port_ctrl i_ctrl (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rstN  (rstN),
    .loadN (loadN),
    .wrEnN (wrEnN),
    .rdEnN (rdEnN),
    .strb  (strb),
    .fifoWr(fifoWr),
    .fifoRd(fifoRd)
  );

  offset_port_dp #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_dp (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .offRdData(offRdData),
    .emptyOff (emptyOff),
    .fullOff  (fullOff)
  );

endmodule

// File: tb/test_offset_port.sv
module test_offset_port;

  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;

  logic        wrClk = 1'b0, rdClk = 1'b0;
  logic        rstN = 1'b0, loadN = 1'b1, wrEnN = 1'b1, rdEnN = 1'b1;
  logic [8:0]  wrData = '0;
  logic [8:0]  offRdData;
  logic        fifoWr, fifoRd;
  logic [15:0] emptyOff, fullOff;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2)  rdClk = ~rdClk;

  offset_port i_offset_port (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .loadN(loadN),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .wrData(wrData), .offRdData(offRdData),
    .fifoWr(fifoWr), .fifoRd(fifoRd), .emptyOff(emptyOff), .fullOff(fullOff)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic doReset(input bit prog);
    wrEnN = 1'b1; rdEnN = 1'b1;
    loadN = prog ? 1'b0 : 1'b1;
    rstN  = 1'b0;
    repeat (4) @(negedge rdClk);
    rstN = 1'b1;
    repeat (2) @(negedge rdClk);
    loadN = 1'b1;
    @(negedge wrClk);
  endtask

  task automatic writeOff(input logic [8:0] d);
    @(negedge wrClk);
    loadN = 1'b0; wrEnN = 1'b0; wrData = d;
    @(negedge wrClk);
    wrEnN = 1'b1; loadN = 1'b1;
  endtask

  task automatic readOff(output logic [8:0] v);
    @(negedge rdClk);
    loadN = 1'b0; rdEnN = 1'b0;
    @(negedge rdClk);
    rdEnN = 1'b1; loadN = 1'b1;
    v = offRdData;
  endtask

  task automatic t_reset_defaults;
    logic [8:0] v;
    doReset(1'b1);
    chk("R6 emptyOff after reset", emptyOff, 32'h7);
    chk("R6 fullOff after reset", fullOff, 32'h7);
    chk("R6 fifoWr idle", fifoWr, 0);
    readOff(v); chk("R1 read empty-low default", v, 7);
    readOff(v); chk("R1 read empty-high default", v, 0);
    repeat (3) @(negedge rdClk);
    readOff(v); chk("R5 read selector parked, full-low", v, 7);
    readOff(v); chk("R5 read full-high", v, 0);
    readOff(v); chk("R1 read wraps to empty-low", v, 7);
  endtask

  task automatic t_full_program;
    logic [8:0] v;
    doReset(1'b1);
    writeOff(9'h012); writeOff(9'h003); writeOff(9'h045); writeOff(9'h001);
    chk("R8 emptyOff assembled", emptyOff, 32'h0612);
    chk("R8 fullOff assembled", fullOff, 32'h0245);
    readOff(v); chk("R5 readback empty-low", v, 9'h012);
    readOff(v); chk("R5 readback empty-high", v, 9'h003);
    readOff(v); chk("R5 readback full-low", v, 9'h045);
    readOff(v); chk("R5 readback full-high", v, 9'h001);
  endtask

  task automatic t_partial;
    doReset(1'b1);
    writeOff(9'h0A1);
    repeat (5) @(negedge wrClk);
    writeOff(9'h005);
    chk("R4 second session hits empty-high", emptyOff, 32'h0AA1);
    chk("R4 fullOff untouched", fullOff, 32'h7);
    repeat (3) @(negedge wrClk);
    writeOff(9'h01C);
    chk("R4 third session hits full-low", fullOff, 32'h001C);
  endtask

  task automatic t_wrap;
    doReset(1'b1);
    writeOff(9'h011); writeOff(9'h022); writeOff(9'h033); writeOff(9'h044);
    writeOff(9'h055);
    chk("R1 fifth write wraps to empty-low", emptyOff, 32'h4455);
    chk("R2 full registers kept", fullOff, 32'h8833);
  endtask

  task automatic t_disabled;
    doReset(1'b1);
    @(negedge wrClk);
    loadN = 1'b0; wrEnN = 1'b1; wrData = 9'h0AA;
    repeat (3) @(negedge wrClk);
    chk("R3 wrEnN high: fifoWr low", fifoWr, 0);
    chk("R3 wrEnN high: emptyOff held", emptyOff, 32'h7);
    loadN = 1'b1; wrEnN = 1'b0; wrData = 9'h0BB;
    #1 chk("R3 load high: fifoWr high", fifoWr, 1);
    repeat (2) @(negedge wrClk);
    wrEnN = 1'b1;
    chk("R3 FIFO write: emptyOff held", emptyOff, 32'h7);
    chk("R3 FIFO write: fullOff held", fullOff, 32'h7);
    rdEnN = 1'b0;
    #1 chk("R11 fifoRd high with load high", fifoRd, 1);
    repeat (2) @(negedge rdClk);
    rdEnN = 1'b1;
    chk("R11 offRdData unchanged", offRdData, 0);
    writeOff(9'h0CC);
    chk("R3 selector not advanced", emptyOff, 32'h00CC);
  endtask

  task automatic t_nonprog;
    doReset(1'b0);
    @(negedge wrClk);
    loadN = 1'b0; wrEnN = 1'b0; wrData = 9'h0EE;
    #1 chk("R7 load ignored: fifoWr high", fifoWr, 1);
    repeat (2) @(negedge wrClk);
    wrEnN = 1'b1;
    chk("R7 offsets untouched", emptyOff, 32'h7);
    rdEnN = 1'b0;
    #1 chk("R7 load ignored: fifoRd high", fifoRd, 1);
    repeat (2) @(negedge rdClk);
    rdEnN = 1'b1; loadN = 1'b1;
    chk("R7 no readback", offRdData, 0);
  endtask

  task automatic t_mask;
    logic [8:0] v;
    doReset(1'b1);
    writeOff(9'h000); writeOff(9'h1FF);
    chk("R9 high bits truncated", emptyOff, 32'hFE00);
    readOff(v); chk("R9 read empty-low", v, 0);
    readOff(v); chk("R9 unused bit reads zero", v, 9'h07F);
  endtask

  task automatic t_reset_selectors;
    logic [8:0] v;
    doReset(1'b1);
    writeOff(9'h0F0); writeOff(9'h002);
    readOff(v); readOff(v); readOff(v);
    doReset(1'b1);
    chk("R10 offsets restored", emptyOff, 32'h7);
    readOff(v); chk("R10 read selector at empty-low", v, 7);
    writeOff(9'h030);
    chk("R10 write selector at empty-low", emptyOff, 32'h0030);
  endtask

  initial begin
    t_reset_defaults();
    t_full_program();
    t_partial();
    t_wrap();
    t_disabled();
    t_nonprog();
    t_mask();
    t_reset_selectors();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule